// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a bus-attached arithmetic unit that multiplies two 16-bit operands in one cycle. It can fold the product into a 48-bit running accumulator. Software programs a control word, writes operands and reads back either the accumulator words or a 32-bit result. All of this goes through a small synchronous register file: address, write strobe, write data and combinational read data.

A 3-bit mode field picks the arithmetic: multiply, negated multiply, add-to-accumulator or subtract-from-accumulator. The same field decides whether the accumulator is written back. Operations fire on an operand write, and the trigger depends on the operand mode:
- In two-operand mode, the operation fires once both operands have been written.
- In single-operand mode, a write to operand B fires it.
- In square mode, a write to operand A fires it.

A new operation may be issued every cycle. A pending accumulator update is forwarded to the next operation.

Top module: `mac_periph`

## Requirements
- R1: Register indices: 0 control, 1 operand A, 2 operand B, 3/4/5 accumulator bits 47:32, 31:16 and 15:0, 8 result bits 31:16, 9 result bits 15:0. Operands and accumulator words read back what is stored. Any other index reads 0, and writes to indices 8, 9 or to unmapped indices change nothing.
- R2: Trigger rules:
  - Square (control bit 5) set: a write to A starts A*A, and writes to B start nothing.
  - Otherwise, with single-operand mode (control bit 4) set, a write to B starts A*B.
  - Otherwise, the operation starts on the write that completes a pair of A and B writes made since the last start or operand clear.
- R3: The control word layout is:
  - bits 2:0 are the mode, ordered {no-write-back, subtract, accumulate};
  - bit 3 selects signed data (1) or unsigned data (0);
  - bit 4 is single-operand mode;
  - bit 5 is square mode;
  - bit 6 clears the operands;
  - bit 7 clears the accumulator;
  - bit 8 is the overflow flag.
  Bits 6 and 7 always read 0.
- R4: Modes x00 and x10 put the low 32 bits of P or -P into the result, where P is the product. That result is readable in the cycle after the triggering write. With unsigned data, x10 behaves as x00.
- R5: Modes 001 and 011 set the accumulator to ACC+P or ACC-P, readable two cycles after the trigger. They set the result to the low 32 bits of ACC+2P or ACC-2P, also readable two cycles after the trigger. In the cycle between, the result still shows its previous value.
- R6: Modes 000 and 010 load the accumulator with P or -P, extended to 48 bits (sign-extended for signed data). The new value is readable two cycles after the trigger.
- R7: Modes 1xx never change the accumulator. Modes 101 and 111 put the low 32 bits of ACC+P or ACC-P into the result, readable in the cycle after the trigger.
- R8: The overflow flag behaves as follows:
  - It is set only by modes 001 and 011. Signed data sets it on a 48-bit signed overflow. Unsigned data sets it on a carry out or a borrow.
  - It is sticky.
  - A control write with bit 8 equal to 0 clears it, and a control write with bit 8 equal to 1 leaves it as it is.
- R9: Operations may be triggered on consecutive cycles. Each one sees the accumulator value left by the one before.
- R10: Writes that start no operation leave the result unchanged.
- R11: Clear actions take effect in one cycle:
  - control bit 6 zeroes both operands and forgets earlier operand writes;
  - control bit 7 zeroes the accumulator and cancels a pending accumulator update.
- R12: A direct write to an accumulator word replaces that word. If an update is pending in the same cycle, the direct write takes priority over it.
- R13: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register index |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The hardest situation to reach is a chain of accumulate operations fired on consecutive cycles. In that chain, every trigger must take a forwarded accumulator value while the delayed result of the previous operation lands in the same cycle. The stimulus reaches it with single-operand mode and a burst of operand-B writes held on successive clock edges. Directed steps then push a signed accumulator to its positive limit and drive an unsigned subtraction below zero, to exercise both overflow sources. A long pseudo-random stream of register writes follows, compared cycle by cycle against a behavioural model, to mix modes, clears and direct accumulator writes.

// File: rtl/mac_periph.sv
module mac_periph #(
  parameter int OPW = 16,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [OPW-1:0] bus_wdata,
  output logic [OPW-1:0] bus_rdata
);
  localparam int PW  = 2 * OPW;
  localparam int ACW = 3 * OPW;
  localparam logic [AW-1:0] R_CTL = AW'(0);
  localparam logic [AW-1:0] R_OPA = AW'(1);
  localparam logic [AW-1:0] R_OPB = AW'(2);
  localparam logic [AW-1:0] R_ACH = AW'(3);
  localparam logic [AW-1:0] R_ACM = AW'(4);
  localparam logic [AW-1:0] R_ACL = AW'(5);
  localparam logic [AW-1:0] R_RSH = AW'(8);
  localparam logic [AW-1:0] R_RSL = AW'(9);

  logic [2:0]     mode;
  logic           sgn, one_op, sq, ovf;
  logic [OPW-1:0] opa, opb;
  logic           have_a, have_b;
  logic [ACW-1:0] acc, pacc;
  logic           pacc_v;
  logic [PW-1:0]  res, pres;
  logic           pres_v;

  logic wr_ctl, wr_a, wr_b, wr_acc, trig, delayed, use_sub, ov;
  assign wr_ctl = bus_we && bus_addr == R_CTL;
  assign wr_a   = bus_we && bus_addr == R_OPA;
  assign wr_b   = bus_we && bus_addr == R_OPB;
  assign wr_acc = bus_we && (bus_addr == R_ACH || bus_addr == R_ACM || bus_addr == R_ACL);

  logic [OPW-1:0] a_n, b_n;
  assign a_n = wr_a ? bus_wdata : opa;
  assign b_n = sq ? a_n : (wr_b ? bus_wdata : opb);

  assign trig = sq ? wr_a :
                one_op ? wr_b :
                ((wr_a && have_b) || (wr_b && have_a));
  assign delayed = !mode[2] && mode[0];
  assign use_sub = mode[1] && (mode[0] || sgn);

  logic [PW-1:0]  xa, xb, prod;
  logic [ACW-1:0] p_ext, term, acc_eff, new_val;
  logic [ACW:0]   ae, pe, full;
  logic [PW-1:0]  dres;
  assign xa      = {{OPW{sgn & a_n[OPW-1]}}, a_n};
  assign xb      = {{OPW{sgn & b_n[OPW-1]}}, b_n};
  assign prod    = xa * xb;
  assign p_ext   = {{OPW{sgn & prod[PW-1]}}, prod};
  assign term    = use_sub ? -p_ext : p_ext;
  assign acc_eff = pacc_v ? pacc : acc;
  assign ae      = {sgn & acc_eff[ACW-1], acc_eff};
  assign pe      = {sgn & p_ext[ACW-1], p_ext};
  assign full    = mode[1] ? ae - pe : ae + pe;
  assign ov      = sgn ? (full[ACW] ^ full[ACW-1]) : full[ACW];
  assign new_val = mode[0] ? full[ACW-1:0] : term;
  assign dres    = PW'(mode[1] ? new_val - p_ext : new_val + p_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; sgn <= 1'b0; one_op <= 1'b0; sq <= 1'b0; ovf <= 1'b0;
      opa <= '0; opb <= '0; have_a <= 1'b0; have_b <= 1'b0;
      acc <= '0; pacc <= '0; pacc_v <= 1'b0;
      res <= '0; pres <= '0; pres_v <= 1'b0;
    end else begin
      pacc_v <= 1'b0;
      pres_v <= 1'b0;
      if (pacc_v) acc <= pacc;
      if (pres_v) res <= pres;
      if (wr_a) opa <= bus_wdata;
      if (wr_b) opb <= bus_wdata;
      if (trig) begin
        have_a <= 1'b0;
        have_b <= 1'b0;
        if (!mode[2]) begin
          pacc   <= new_val;
          pacc_v <= 1'b1;
        end
        if (delayed) begin
          pres   <= dres;
          pres_v <= 1'b1;
          ovf    <= ovf | ov;
        end else begin
          res <= new_val[PW-1:0];
        end
      end else begin
        if (wr_a) have_a <= 1'b1;
        if (wr_b) have_b <= 1'b1;
      end
      if (bus_we && bus_addr == R_ACH) acc[ACW-1:PW] <= bus_wdata;
      if (bus_we && bus_addr == R_ACM) acc[PW-1:OPW] <= bus_wdata;
      if (bus_we && bus_addr == R_ACL) acc[OPW-1:0]  <= bus_wdata;
      if (wr_ctl) begin
        mode   <= bus_wdata[2:0];
        sgn    <= bus_wdata[3];
        one_op <= bus_wdata[4];
        sq     <= bus_wdata[5];
        ovf    <= ovf & bus_wdata[8];
        if (bus_wdata[6]) begin
          opa <= '0; opb <= '0; have_a <= 1'b0; have_b <= 1'b0;
        end
        if (bus_wdata[7]) acc <= '0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      R_CTL:   bus_rdata = OPW'({ovf, 2'b00, sq, one_op, sgn, mode});
      R_OPA:   bus_rdata = opa;
      R_OPB:   bus_rdata = opb;
      R_ACH:   bus_rdata = acc[ACW-1:PW];
      R_ACM:   bus_rdata = acc[PW-1:OPW];
      R_ACL:   bus_rdata = acc[OPW-1:0];
      R_RSH:   bus_rdata = res[PW-1:OPW];
      R_RSL:   bus_rdata = res[OPW-1:0];
      default: bus_rdata = '0;
    endcase
  end

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_ctl) |=> ovf);
  assert_ovf_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !(trig && delayed)) |=> !ovf);
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pacc_v && !wr_acc && !wr_ctl) |=> $stable(acc));
  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !pres_v) |=> $stable(res));
  assert_opclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[6]) |=> (opa == '0 && opb == '0 && !have_a && !have_b));
  assert_accclear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[7]) |=> (acc == '0 && !pacc_v));
endmodule

// File: tb/mac_periph_bench.sv
`timescale 1ns/1ps
module mac_periph_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  mac_periph u_mac_periph (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  // behavioural reference state
  bit [15:0] ma, mb;
  bit [47:0] macc, mpacc;
  bit [31:0] mres, mpres;
  bit        mpv, mrv, movf, ms, mone, msq, mha, mhb;
  bit [2:0]  mmode;

  function automatic bit [63:0] ext16(bit [15:0] v, bit s);
    return s ? {{48{v[15]}}, v} : {48'b0, v};
  endfunction
  function automatic bit [63:0] ext48(bit [47:0] v, bit s);
    return s ? {{16{v[47]}}, v} : {16'b0, v};
  endfunction
  function automatic bit [15:0] mread(bit [4:0] a);
    case (a)
      5'd0: return {7'b0, movf, 2'b00, msq, mone, ms, mmode};
      5'd1: return ma;
      5'd2: return mb;
      5'd3: return macc[47:32];
      5'd4: return macc[31:16];
      5'd5: return macc[15:0];
      5'd8: return mres[31:16];
      5'd9: return mres[15:0];
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string req, bit [15:0] got, bit [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma = 0; mb = 0; macc = 0; mpacc = 0; mres = 0; mpres = 0;
      mpv = 0; mrv = 0; movf = 0; ms = 0; mone = 0; msq = 0; mha = 0; mhb = 0; mmode = 0;
    end else begin
      bit wa, wb, go;
      bit [15:0] an, bn;
      bit [63:0] P, A, r, t;
      bit [47:0] nacc;
      bit [31:0] nres;
      bit npv, nrv;
      chk("every-cycle readback", bus_rdata, mread(bus_addr));
      wa = bus_we && bus_addr == 5'd1;
      wb = bus_we && bus_addr == 5'd2;
      an = wa ? bus_wdata : ma;
      bn = msq ? an : (wb ? bus_wdata : mb);
      if (msq) go = wa;
      else if (mone) go = wb;
      else go = (wa && mhb) || (wb && mha);
      nacc = mpv ? mpacc : macc;
      nres = mrv ? mpres : mres;
      npv = 0; nrv = 0;
      if (wa) ma = bus_wdata;
      if (wb) mb = bus_wdata;
      if (go) begin
        P = ext16(an, ms) * ext16(bn, ms);
        A = ext48(mpv ? mpacc : macc, ms);
        if (mmode[0]) begin
          r = mmode[1] ? A - P : A + P;
          if (!mmode[2]) begin
            if (ext48(r[47:0], ms) != r) movf = 1;
            t = mmode[1] ? r - P : r + P;
            mpres = t[31:0]; nrv = 1;
          end else nres = r[31:0];
        end else begin
          r = (mmode[1] && ms) ? -P : P;
          nres = r[31:0];
        end
        if (!mmode[2]) begin mpacc = r[47:0]; npv = 1; end
        mha = 0; mhb = 0;
      end else begin
        if (wa) mha = 1;
        if (wb) mhb = 1;
      end
      if (bus_we && bus_addr == 5'd3) nacc[47:32] = bus_wdata;
      if (bus_we && bus_addr == 5'd4) nacc[31:16] = bus_wdata;
      if (bus_we && bus_addr == 5'd5) nacc[15:0] = bus_wdata;
      if (bus_we && bus_addr == 5'd0) begin
        mmode = bus_wdata[2:0]; ms = bus_wdata[3]; mone = bus_wdata[4]; msq = bus_wdata[5];
        movf = movf & bus_wdata[8];
        if (bus_wdata[6]) begin ma = 0; mb = 0; mha = 0; mhb = 0; end
        if (bus_wdata[7]) begin nacc = 0; npv = 0; end
      end
      macc = nacc; mres = nres; mpv = npv; mrv = nrv;
    end
  end

  task automatic wr(bit [4:0] a, bit [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask
  task automatic rdchk(string req, bit [4:0] a, bit [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask
  task automatic idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    rdchk("R13 ctrl", 5'd0, 16'h0);
    rdchk("R13 acc low", 5'd5, 16'h0);
    rdchk("R13 res high", 5'd8, 16'h0);
    // R2/R4/R6 unsigned two-operand multiply
    wr(5'd0, 16'h0000);
    wr(5'd1, 16'h1234);
    rdchk("R2 one operand alone", 5'd9, 16'h0000);
    wr(5'd2, 16'h0010);
    rdchk("R4 res high", 5'd8, 16'h0001);
    rdchk("R4 res low", 5'd9, 16'h2340);
    rdchk("R6 acc not yet", 5'd5, 16'h0000);
    idle();
    rdchk("R6 acc low", 5'd5, 16'h2340);
    rdchk("R6 acc mid", 5'd4, 16'h0001);
    // R5 signed accumulate
    wr(5'd0, 16'h0009);
    wr(5'd1, 16'hFFFE);
    wr(5'd2, 16'h0003);
    rdchk("R5 res still old", 5'd9, 16'h2340);
    idle();
    rdchk("R5 res low", 5'd9, 16'h2334);
    rdchk("R5 acc low", 5'd5, 16'h233A);
    // R12 direct accumulator writes, R8 signed overflow
    wr(5'd3, 16'h7FFF); wr(5'd4, 16'hFFFF); wr(5'd5, 16'hFFFF);
    rdchk("R12 acc high", 5'd3, 16'h7FFF);
    rdchk("R12 acc low", 5'd5, 16'hFFFF);
    wr(5'd1, 16'h0001);
    wr(5'd2, 16'h0001);
    rdchk("R8 signed overflow set", 5'd0, 16'h0109);
    idle();
    rdchk("R5 acc wraps high", 5'd3, 16'h8000);
    wr(5'd0, 16'h0108);
    rdchk("R8 write 1 keeps", 5'd0, 16'h0108);
    wr(5'd1, 16'h0002);
    wr(5'd2, 16'h0002);
    rdchk("R8 mode 000 leaves flag", 5'd0, 16'h0108);
    wr(5'd0, 16'h0008);
    rdchk("R8 write 0 clears", 5'd0, 16'h0008);
    // R5/R8 unsigned subtract borrow
    wr(5'd0, 16'h0003);
    wr(5'd1, 16'h0003);
    wr(5'd2, 16'h0002);
    idle();
    rdchk("R5 sub acc high", 5'd3, 16'hFFFF);
    rdchk("R5 sub acc low", 5'd5, 16'hFFFE);
    rdchk("R5 sub res low", 5'd9, 16'hFFF8);
    rdchk("R8 unsigned borrow", 5'd0, 16'h0103);
    // R7 no write-back accumulate
    wr(5'd0, 16'h0005);
    wr(5'd1, 16'h0001);
    wr(5'd2, 16'h0005);
    rdchk("R7 res low", 5'd9, 16'h0003);
    rdchk("R7 res high", 5'd8, 16'h0000);
    rdchk("R8 mode 101 no flag", 5'd0, 16'h0005);
    idle();
    rdchk("R7 acc kept", 5'd5, 16'hFFFE);
    // R4/R6 negate
    wr(5'd0, 16'h000A);
    wr(5'd1, 16'h0003);
    wr(5'd2, 16'h0004);
    rdchk("R4 neg res low", 5'd9, 16'hFFF4);
    rdchk("R4 neg res high", 5'd8, 16'hFFFF);
    idle();
    rdchk("R6 neg acc mid", 5'd4, 16'hFFFF);
    rdchk("R6 neg acc low", 5'd5, 16'hFFF4);
    wr(5'd0, 16'h0002);
    wr(5'd1, 16'h0003);
    wr(5'd2, 16'h0004);
    rdchk("R4 unsigned neg is multiply", 5'd9, 16'h000C);
    // R2 single-operand, R10 hold
    wr(5'd0, 16'h0010);
    wr(5'd2, 16'h0005);
    rdchk("R2 single-operand", 5'd9, 16'h000F);
    wr(5'd2, 16'h0006);
    rdchk("R2 single-operand again", 5'd9, 16'h0012);
    wr(5'd1, 16'h0007);
    rdchk("R10 A write holds", 5'd9, 16'h0012);
    // R2 square, R10
    wr(5'd0, 16'h0020);
    wr(5'd1, 16'h0100);
    rdchk("R2 square high", 5'd8, 16'h0001);
    wr(5'd2, 16'h0009);
    rdchk("R10 B in square holds", 5'd8, 16'h0001);
    // R11 operand clear, R3 clear bits read 0, R2 pairing
    wr(5'd0, 16'h0040);
    rdchk("R3 clear bit reads 0", 5'd0, 16'h0000);
    rdchk("R11 A cleared", 5'd1, 16'h0000);
    rdchk("R11 B cleared", 5'd2, 16'h0000);
    wr(5'd1, 16'h0002);
    rdchk("R2 pair incomplete", 5'd8, 16'h0001);
    wr(5'd1, 16'h0003);
    wr(5'd2, 16'h0005);
    rdchk("R2 pair complete", 5'd9, 16'h000F);
    rdchk("R2 pair high", 5'd8, 16'h0000);
    idle();
    // R11 accumulator clear, R9 back-to-back
    wr(5'd0, 16'h0091);
    rdchk("R11 acc cleared", 5'd5, 16'h0000);
    rdchk("R3 ctrl readback", 5'd0, 16'h0011);
    wr(5'd1, 16'h0002);
    @(negedge clk); bus_we = 1'b1; bus_addr = 5'd2; bus_wdata = 16'h0003;
    @(negedge clk); bus_wdata = 16'h0004;
    @(negedge clk); bus_wdata = 16'h0005;
    @(negedge clk); bus_we = 1'b0;
    idle();
    rdchk("R9 chained acc", 5'd5, 16'h0018);
    rdchk("R9 chained res", 5'd9, 16'h0022);
    // R1 map
    rdchk("R1 unmapped reads 0", 5'd6, 16'h0000);
    wr(5'd8, 16'hABCD);
    rdchk("R1 result write ignored", 5'd8, 16'h0000);
    rdchk("R1 operand A readback", 5'd1, 16'h0002);
    // pseudo-random stream against the model
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      bus_we = lf[3];
      case (lf[7:5])
        3'd0: bus_addr = 5'd0;
        3'd1, 3'd2: bus_addr = 5'd1;
        3'd3, 3'd4: bus_addr = 5'd2;
        3'd5: bus_addr = 5'(3 + (lf[9:8] % 3));
        3'd6: bus_addr = lf[10] ? 5'd8 : 5'd9;
        default: bus_addr = 5'd6;
      endcase
      bus_wdata = (bus_addr == 5'd0) ? {7'b0, lf[20:12]} : lf[31:16];
    end
    @(negedge clk); bus_we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule